// File: doc/BRIEF.md
# Periodic Relock Scheduler with Oscillator Pre-Wake

This block runs on the system clock and decides when a low-power, temperature-uncompensated oscillator is re-trimmed against a stable reference oscillator. A programmable interval, counted in system clock cycles, separates two relock events. Before each relock the block switches the reference oscillator on early, by a programmable number of cycles, so that it has settled when the lock begins. It then fires a one-cycle start pulse to the locking engine and waits for that engine to report completion. On completion it switches the reference oscillator off and begins the next interval at once.

The interval and wake-ahead values are captured only when a new interval begins. A write during an interval therefore affects only the next one. The captured interval is raised to a floor of 368 cycles, which is the shortest time a lock can take. It is also raised to one more than the wake-ahead value, so every wake-up falls inside its own interval and two locks never overlap. Dropping the enable freezes the countdown. A lock that is already in progress always runs to completion.

Top module: `relock_sched`

## Requirements
- R1: A new interval starts on the clock edge where `run_en` is sampled high while the block is idle, or on the edge where `lock_done` is accepted during a lock. `lock_start` is then high in the cycle that follows the E-th subsequent edge, where E is the effective interval.
- R2: The effective interval E is the largest of the captured `period_cfg`, the constant 368, and the captured `wake_cfg` plus one.
- R3: `ref_pwr_on` rises exactly `wake_cfg` cycles before `lock_start` rises. When `wake_cfg` is 0, both rise in the same cycle.
- R4: `lock_start` is high for exactly one cycle per lock. `ref_pwr_on` stays 1 from its rise until `lock_done` is accepted.
- R5: When `lock_done` is sampled high during a lock, `ref_pwr_on` is 0 in the following cycle.
- R6: `lock_done` has no effect outside a lock. It neither powers the reference down nor alters the interval timing.
- R7: Each cycle with `run_en` low during an interval freezes the countdown, so `lock_start` is delayed by that many cycles.
- R8: `period_cfg` and `wake_cfg` are captured only when an interval starts. Changes made during an interval do not affect that interval.
- R9: During and straight after reset, `ref_pwr_on` and `lock_start` are 0.
- R10: `ref_pwr_on` makes exactly one rise and one fall per lock.
- R11: If `run_en` is low when `lock_done` is accepted, the block becomes idle. It raises neither output until `run_en` is high again, which starts a fresh interval as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables scheduling; low freezes the countdown |
| period_cfg | input | 32 | Interval between locks, in system clock cycles |
| wake_cfg | input | 16 | Cycles by which reference power-up precedes the lock start |
| lock_done | input | 1 | Locking engine reports completion |
| ref_pwr_on | output | 1 | 1 = reference oscillator powered, 0 = powered down |
| lock_start | output | 1 | One-cycle pulse that starts a lock |

## Verification
The assertions assume that `lock_done` arrives only in answer to a start pulse. A stray assertion outside a lock must be harmless, but the assertions do not depend on it. They also assume `wake_cfg` is narrower than the interval counter, so that the wake-ahead plus one always fits in the counter. The bench keeps `wake_cfg` and `period_cfg` in ranges where one lock finishes within a few thousand cycles. It pulses `lock_done` for exactly one cycle, either in a lock or, on purpose, in the middle of a countdown. It changes configuration only at known points: during a lock, or deliberately in the middle of an interval.

// File: rtl/relock_pkg.sv
package relock_pkg;
  typedef enum logic [1:0] {
    SCH_IDLE  = 2'd0,
    SCH_COUNT = 2'd1,
    SCH_LOCK  = 2'd2
  } sched_state_e;
endpackage

// File: rtl/relock_timer.sv
module relock_timer #(
  parameter int CNT_W = 32,
  parameter int SET_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [SET_W-1:0] wake_val,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             wake
);
  localparam int CW1 = CNT_W + 1;

  logic [SET_W-1:0] wake_q;
  logic [CW1-1:0]   wake_mark;

  // Wake window opens when the remaining count reaches wake_q + 1.
  function automatic logic [CW1-1:0] wake_threshold(input logic [SET_W-1:0] w);
    return CW1'(w) + CW1'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      wake_q <= '0;
    end else if (load) begin
      cnt    <= load_val;
      wake_q <= wake_val;
    end else if (run && (cnt > CNT_W'(1))) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign wake_mark = wake_threshold(wake_q);
  assign expire    = run && (cnt == CNT_W'(1));
  assign wake      = run && ({1'b0, cnt} <= wake_mark);
endmodule

// File: rtl/relock_fsm.sv
module relock_fsm
  import relock_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         lock_done,
  input  logic         expire,
  input  logic         wake,
  output logic         load,
  output logic         run,
  output logic         lock_start,
  output logic         pwr_on,
  output sched_state_e state
);
  sched_state_e nxt;

  always_comb begin
    nxt  = state;
    load = 1'b0;
    run  = 1'b0;
    unique case (state)
      SCH_IDLE: begin
        if (run_en) begin
          load = 1'b1;
          nxt  = SCH_COUNT;
        end
      end
      SCH_COUNT: begin
        run = run_en;
        if (expire) nxt = SCH_LOCK;
      end
      SCH_LOCK: begin
        if (lock_done) begin
          if (run_en) begin
            load = 1'b1;
            nxt  = SCH_COUNT;
          end else begin
            nxt = SCH_IDLE;
          end
        end
      end
      default: nxt = SCH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SCH_IDLE;
      lock_start <= 1'b0;
      pwr_on     <= 1'b0;
    end else begin
      state      <= nxt;
      lock_start <= (state == SCH_COUNT) && expire;
      if ((state == SCH_LOCK) && lock_done)
        pwr_on <= 1'b0;
      else if ((state == SCH_COUNT) && (wake || expire))
        pwr_on <= 1'b1;
    end
  end
endmodule

// File: rtl/relock_sched.sv
module relock_sched
  import relock_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int SET_W    = 16,
  parameter int MIN_LOCK = 368
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [SET_W-1:0] wake_cfg,
  input  logic             lock_done,
  output logic             ref_pwr_on,
  output logic             lock_start
);
  localparam int CW1 = CNT_W + 1;

  // Raise the requested period to the lock floor and past the wake-ahead.
  function automatic logic [CNT_W-1:0] eff_interval(
    input logic [CNT_W-1:0] per,
    input logic [SET_W-1:0] wk
  );
    logic [CW1-1:0] v;
    logic [CW1-1:0] wk_floor;
    v        = {1'b0, per};
    wk_floor = CW1'(wk) + CW1'(1);
    if (v < CW1'(MIN_LOCK)) v = CW1'(MIN_LOCK);
    if (v < wk_floor)       v = wk_floor;
    return v[CNT_W-1:0];
  endfunction

  // Named internal events, observed by the bound checker.
  logic             tmr_load;
  logic             tmr_run;
  logic [CNT_W-1:0] tmr_load_val;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_expire;
  logic             tmr_wake;
  logic             in_lock;
  sched_state_e     sched_state;

  assign tmr_load_val = eff_interval(period_cfg, wake_cfg);
  assign in_lock      = (sched_state == SCH_LOCK);

  relock_timer #(
    .CNT_W(CNT_W),
    .SET_W(SET_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_load_val),
    .wake_val(wake_cfg),
    .run     (tmr_run),
    .cnt     (tmr_cnt),
    .expire  (tmr_expire),
    .wake    (tmr_wake)
  );

  relock_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .lock_done (lock_done),
    .expire    (tmr_expire),
    .wake      (tmr_wake),
    .load      (tmr_load),
    .run       (tmr_run),
    .lock_start(lock_start),
    .pwr_on    (ref_pwr_on),
    .state     (sched_state)
  );
endmodule

// File: rtl/relock_sched_chk.sv
module relock_sched_chk #(
  parameter int CNT_W    = 32,
  parameter int MIN_LOCK = 368
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_done,
  input logic             lock_start,
  input logic             ref_pwr_on,
  input logic             tmr_load,
  input logic             tmr_run,
  input logic [CNT_W-1:0] tmr_load_val,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic             in_lock
);
  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_start |=> !lock_start);

  assert_powered_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_start |-> ref_pwr_on);

  assert_powered_in_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_lock |-> ref_pwr_on);

  // R5 and R6: power only drops after lock_done was accepted during a lock.
  assert_fall_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_pwr_on) |-> $past(lock_done && in_lock));

  assert_rise_outside_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_pwr_on) |-> !$past(in_lock));

  assert_floor_on_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_load |-> (tmr_load_val >= CNT_W'(MIN_LOCK)));

  assert_freeze_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_run && !tmr_load) |=> $stable(tmr_cnt));
endmodule

bind relock_sched relock_sched_chk #(
  .CNT_W   (CNT_W),
  .MIN_LOCK(MIN_LOCK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lock_done   (lock_done),
  .lock_start  (lock_start),
  .ref_pwr_on  (ref_pwr_on),
  .tmr_load    (tmr_load),
  .tmr_run     (tmr_run),
  .tmr_load_val(tmr_load_val),
  .tmr_cnt     (tmr_cnt),
  .in_lock     (in_lock)
);

// File: tb/relock_sched_bench.sv
module relock_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [31:0] period_cfg = 32'd400;
  logic [15:0] wake_cfg = 16'd10;
  logic        lock_done = 1'b0;
  logic        ref_pwr_on;
  logic        lock_start;

  longint cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  relock_sched u_relock_sched (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .period_cfg(period_cfg),
    .wake_cfg(wake_cfg), .lock_done(lock_done),
    .ref_pwr_on(ref_pwr_on), .lock_start(lock_start)
  );

  // Expected spacing: settle+1 dominates, else the 368 floor, else the period.
  function automatic longint exp_gap(input longint per, input longint wk);
    longint g;
    g = (per >= 368) ? per : 368;
    if (wk >= g) g = wk + 1;
    return g;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
  endtask

  // Wait for the start pulse of an interval begun at the edge after negedge t0.
  task automatic wait_lock(input longint t0, input longint gap, input longint wk, input string tag);
    longint pw_at = -1;
    int rises = 0;
    int falls = 0;
    bit prev = ref_pwr_on;
    bit seen = 1'b0;
    while (!seen && (cyc - t0 <= gap + 100)) begin
      @(negedge clk);
      if (ref_pwr_on && !prev) begin rises++; pw_at = cyc; end
      if (!ref_pwr_on && prev) falls++;
      prev = ref_pwr_on;
      seen = lock_start;
    end
    check(seen, {"R1 start seen ", tag}, seen, 1);
    check(cyc - t0 - 1 == gap, {"R1/R2 interval ", tag}, cyc - t0 - 1, gap);
    check(cyc - pw_at == wk, {"R3 wake lead ", tag}, cyc - pw_at, wk);
    check(rises == 1 && falls == 0, {"R10 one rise ", tag}, rises * 10 + falls, 10);
  endtask

  task automatic finish_lock(input int d, output longint t0);
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      check(ref_pwr_on == 1'b1, "R4 power held in lock", ref_pwr_on, 1);
      check(lock_start == 1'b0, "R4 single-cycle start", lock_start, 0);
    end
    lock_done = 1'b1;
    t0 = cyc;
    @(negedge clk);
    lock_done = 1'b0;
    check(ref_pwr_on == 1'b0, "R5 power down after done", ref_pwr_on, 0);
  endtask

  task automatic next_lock(input longint per, input longint wk, input int d, input string tag);
    longint t0;
    period_cfg = 32'(per);
    wake_cfg   = 16'(wk);
    finish_lock(d, t0);
    wait_lock(t0, exp_gap(per, wk), wk, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    report();
    $finish;
  end

  initial begin
    longint t0;
    int hi_cnt;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(ref_pwr_on == 1'b0 && lock_start == 1'b0, "R9 reset outputs", {ref_pwr_on, lock_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ref_pwr_on == 1'b0 && lock_start == 1'b0, "R9 after reset", {ref_pwr_on, lock_start}, 0);

    // R1: first interval from enable, then a periodic one.
    run_en = 1'b1;
    t0 = cyc;
    wait_lock(t0, 400, 10, "first");
    next_lock(400, 10, 3, "periodic");

    // R2 corners: floor, exact floor, wake dominating, zero wake.
    next_lock(0, 0, 0, "R2 zero period");
    next_lock(367, 3, 1, "R2 just below floor");
    next_lock(368, 367, 2, "R2 floor equals wake+1");
    next_lock(369, 0, 0, "R2 just above floor");
    next_lock(400, 500, 4, "R2 wake dominates");
    next_lock(5, 0, 1, "R2 tiny period");

    // R8: change configuration mid-interval; old values still apply.
    period_cfg = 32'd450; wake_cfg = 16'd12;
    finish_lock(1, t0);
    repeat (20) @(negedge clk);
    period_cfg = 32'd900; wake_cfg = 16'd60;
    wait_lock(t0, 450, 12, "R8 old config kept");
    next_lock(900, 60, 0, "R8 new config at reload");

    // R7: pause the countdown for 30 cycles before the wake window.
    period_cfg = 32'd800; wake_cfg = 16'd20;
    finish_lock(2, t0);
    repeat (50) @(negedge clk);
    run_en = 1'b0;
    repeat (30) @(negedge clk);
    check(lock_start == 1'b0 && ref_pwr_on == 1'b0, "R7 quiet while paused", {ref_pwr_on, lock_start}, 0);
    run_en = 1'b1;
    wait_lock(t0, 830, 20, "R7 paused interval");

    // R6: stray lock_done during a countdown.
    period_cfg = 32'd500; wake_cfg = 16'd8;
    finish_lock(1, t0);
    repeat (100) @(negedge clk);
    lock_done = 1'b1;
    @(negedge clk);
    lock_done = 1'b0;
    check(ref_pwr_on == 1'b0, "R6 stray done ignored", ref_pwr_on, 0);
    wait_lock(t0, 500, 8, "R6 timing unchanged");

    // R11: disabled at completion -> idle until re-enabled.
    run_en = 1'b0;
    period_cfg = 32'd600; wake_cfg = 16'd30;
    finish_lock(2, t0);
    hi_cnt = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (lock_start || ref_pwr_on) hi_cnt++;
    end
    check(hi_cnt == 0, "R11 idle while disabled", hi_cnt, 0);
    run_en = 1'b1;
    t0 = cyc;
    wait_lock(t0, 600, 30, "R11 restart");

    // Constrained random rounds.
    for (int r = 0; r < 25; r++) begin
      longint per = longint'($urandom_range(1500, 0));
      longint wk  = longint'($urandom_range(600, 0));
      int d = int'($urandom_range(4, 0));
      next_lock(per, wk, d, "random");
    end

    report();
    $finish;
  end
endmodule